// File: doc/BRIEF.md
# Signed/Unsigned Word and Byte Multiplier with Fractional Scaling

This block forms the product of two 16-bit operands for a 40-bit DSP accumulator datapath. Each operand has its own signedness flag, so signed, unsigned and mixed-sign multiplies all run through one array. Each operand is widened to 17 bits, sign-filled when it is marked signed and zero-filled when it is not, and then goes into a single 17 x 17 signed multiplier.

A post-scaler sits after the array. It can pass the integer product through, or double it to give a 1.31 fractional result from two Q15 operands. In byte mode only the low 8 bits of each operand are used, and the result is the exact 16-bit product.

The result is registered once. A valid strobe goes along with it. When no new operation is presented, the output holds its last value. Any saturation, for example of the fractional -1.0 x -1.0 case, is left to the accumulator stage that follows.

Top module: `mulsc_top`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `out_valid` and `product` are cleared to zero on that edge.
- R2: `out_valid` equals the value `in_valid` had at the previous rising edge (one-cycle latency).
- R3: In word mode (`byte_mode`=0) with `frac_mode`=0, the registered `product` is the exact product. Each operand is read as 16-bit two's complement when its signed flag is 1 and as unsigned when the flag is 0. The product is given as a 40-bit two's-complement value.
- R4: The R3 rule also holds when exactly one of `a_signed`/`b_signed` is 1 (mixed sign), for example 0xFFFF signed times 0xFFFF unsigned gives -65535.
- R5: In word mode with `frac_mode`=1, `product` is twice the R3 product. It is kept to 33 bits (modulo 2^33) and sign-extended from bit 32. The result is not clamped: 0x8000 x 0x8000, both signed, gives 40'h00_8000_0000.
- R6: With `byte_mode`=1, only bits 7:0 of each operand are used, with signedness taken per operand. Bits 15:8 have no effect. `product` is the exact 16-bit product in 40-bit two's complement, so both-unsigned results have bits 39:16 equal to zero.
- R7: With `byte_mode`=1, `frac_mode` has no effect on `product`.
- R8: When `in_valid` is 0 at a rising edge, `product` keeps its previous value.
- R9: Whenever `out_valid` is 1, bits 39:33 of `product` all equal bit 32 (a 33-bit result, sign-extended).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A new operation is presented this cycle |
| opa | input | 16 | Operand A |
| opb | input | 16 | Operand B |
| a_signed | input | 1 | 1: operand A is two's complement; 0: unsigned |
| b_signed | input | 1 | 1: operand B is two's complement; 0: unsigned |
| frac_mode | input | 1 | 1: 1.31 fractional scaling in word mode |
| byte_mode | input | 1 | 1: multiply low bytes, 16-bit result |
| out_valid | output | 1 | `product` holds a result from the previous cycle's operation |
| product | output | 40 | Registered, sign-extended result |

## Verification
Directed vectors cover the cases that tell the extension rules apart:
- 0x7FFF x 0x8000 and 0xFFFF x 0xFFFF, each under all four signedness pairs, separate zero-fill from sign-fill on each side of the array.
- 0x8000 x 0x8000 in fractional mode confirms the unclamped +1.0 result.

Byte-mode vectors put non-zero upper bytes on the operands and flip `frac_mode`. A wrong byte select or a leaking scaler therefore changes the result.

Every combination of the extreme values 0x0000, 0x7FFF, 0x8000 and 0xFFFF with all sixteen flag settings is run. Random operands and modes follow, mixed with idle cycles so that the hold behaviour is tested against fresh operand values.

// File: rtl/mulsc_pkg.sv
// Package: shared mode encoding for the multiplier/scaler.
// Assumes: one mode is active per operation; byte mode overrides fractional.
package mulsc_pkg;

    // Output scaling selected by the post-scaler
    typedef enum logic [1:0] {
        SCALE_INT  = 2'd0,
        SCALE_FRAC = 2'd1,
        SCALE_BYTE = 2'd2
    } scale_mode_e;

    // Decode the mode flags into one scaling mode
    function automatic scale_mode_e decode_mode(input logic frac_f, input logic byte_f);
        if (byte_f)      return SCALE_BYTE;
        else if (frac_f) return SCALE_FRAC;
        else             return SCALE_INT;
    endfunction

endpackage

// File: rtl/mulsc_extend.sv
// Module: widens one operand into the 17-bit signed array input.
// A signed operand is sign-filled and an unsigned one zero-filled.
// In byte mode only the low BYTE_W bits are used and the rest are ignored.
// Assumes: BYTE_W < OP_W.
module mulsc_extend #(
    parameter int OP_W   = 16,
    parameter int BYTE_W = 8
) (
    input  logic [OP_W-1:0] op,
    input  logic            is_signed,
    input  logic            byte_sel,
    output logic [OP_W:0]   ext
);
    localparam int FILL_BYTE = OP_W + 1 - BYTE_W;

    // Pick the operand width and fill the upper bits
    always_comb begin
        if (byte_sel) begin
            ext = {{FILL_BYTE{is_signed & op[BYTE_W-1]}}, op[BYTE_W-1:0]};
        end else begin
            ext = {is_signed & op[OP_W-1], op};
        end
    end
endmodule

// File: rtl/mulsc_array.sv
// Module: signed EXT_W x EXT_W multiply array, full 2*EXT_W product.
// Assumes: the inputs are already in two's complement (see mulsc_extend).
module mulsc_array #(
    parameter int EXT_W = 17
) (
    input  logic [EXT_W-1:0]   a,
    input  logic [EXT_W-1:0]   b,
    output logic [2*EXT_W-1:0] p
);
    localparam int FULL_W = 2 * EXT_W;

    logic signed [FULL_W-1:0] a_w;
    logic signed [FULL_W-1:0] b_w;

    // Sign-widen both inputs so the multiply runs at full width
    always_comb begin
        a_w = {{EXT_W{a[EXT_W-1]}}, a};
        b_w = {{EXT_W{b[EXT_W-1]}}, b};
    end

    // Signed product, kept to the full width
    always_comb begin
        p = a_w * b_w;
    end
endmodule

// File: rtl/mulsc_scaler.sv
// Module: post-scaler that selects the integer, 1.31 fractional or byte result
// and sign-extends it to RES_W.
// Assumes: p is the exact product of EXT_W-bit signed inputs and RES_W > 2*EXT_W.
module mulsc_scaler
    import mulsc_pkg::*;
#(
    parameter int EXT_W  = 17,
    parameter int BYTE_W = 8,
    parameter int RES_W  = 40
) (
    input  logic [2*EXT_W-1:0] p,
    input  scale_mode_e        mode,
    input  logic               any_signed,
    output logic [RES_W-1:0]   res
);
    localparam int FULL_W  = 2 * EXT_W;
    localparam int PROD_W  = FULL_W - 1;        // 33-bit result width
    localparam int BRES_W  = 2 * BYTE_W;        // byte result width
    localparam int FILL_I  = RES_W - FULL_W;
    localparam int FILL_F  = RES_W - PROD_W;
    localparam int FILL_B  = RES_W - BRES_W;

    logic [PROD_W-1:0] frac_w;
    logic              byte_sign;

    // Double the product and keep PROD_W bits for the 1.31 result
    always_comb begin
        frac_w = {p[PROD_W-2:0], 1'b0};
    end

    // The byte result's top bit is a sign only when an operand is signed
    always_comb begin
        byte_sign = any_signed & p[BRES_W-1];
    end

    // Select the scaled result and extend it to RES_W
    always_comb begin
        unique case (mode)
            SCALE_FRAC: res = {{FILL_F{frac_w[PROD_W-1]}}, frac_w};
            SCALE_BYTE: res = {{FILL_B{byte_sign}}, p[BRES_W-1:0]};
            default:    res = {{FILL_I{p[FULL_W-1]}}, p};
        endcase
    end
endmodule

// File: rtl/mulsc_top.sv
// Module: registered signed/unsigned multiplier with fractional and byte scaling.
// Structure: two operand extenders feed one 17x17 array, then a post-scaler
// and an output register.
// Assumes: synchronous active-low reset; one operation accepted per cycle.
module mulsc_top
    import mulsc_pkg::*;
#(
    parameter int OP_W   = 16,
    parameter int BYTE_W = 8,
    parameter int RES_W  = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [OP_W-1:0]  opa,
    input  logic [OP_W-1:0]  opb,
    input  logic             a_signed,
    input  logic             b_signed,
    input  logic             frac_mode,
    input  logic             byte_mode,
    output logic             out_valid,
    output logic [RES_W-1:0] product
);
    localparam int EXT_W  = OP_W + 1;
    localparam int FULL_W = 2 * EXT_W;
    localparam int N_OPS  = 2;

    logic [OP_W-1:0]   op_in  [N_OPS];
    logic              sgn_in [N_OPS];
    logic [EXT_W-1:0]  op_ext [N_OPS];
    logic [FULL_W-1:0] raw_p;
    logic [RES_W-1:0]  scaled;
    scale_mode_e       mode;

    // Gather the operands and their flags for the extender loop
    always_comb begin
        op_in[0]  = opa;
        op_in[1]  = opb;
        sgn_in[0] = a_signed;
        sgn_in[1] = b_signed;
        mode      = decode_mode(frac_mode, byte_mode);
    end

    // One extender per operand
    for (genvar gi = 0; gi < N_OPS; gi++) begin : g_ext
        mulsc_extend #(.OP_W(OP_W), .BYTE_W(BYTE_W)) u_ext (
            .op        (op_in[gi]),
            .is_signed (sgn_in[gi]),
            .byte_sel  (byte_mode),
            .ext       (op_ext[gi])
        );
    end

    mulsc_array #(.EXT_W(EXT_W)) u_array (
        .a (op_ext[0]),
        .b (op_ext[1]),
        .p (raw_p)
    );

    mulsc_scaler #(.EXT_W(EXT_W), .BYTE_W(BYTE_W), .RES_W(RES_W)) u_scale (
        .p          (raw_p),
        .mode       (mode),
        .any_signed (a_signed | b_signed),
        .res        (scaled)
    );

    // Output register: capture on valid, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            product   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) product <= scaled;
        end
    end
endmodule

// File: rtl/mulsc_checker.sv
// Module: property checker for mulsc_top, attached by bind.
// Assumes: the result is 33 bits sign-extended to RES_W, with byte results 2*BYTE_W wide.
module mulsc_checker #(
    parameter int BYTE_W = 8,
    parameter int RES_W  = 40
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             a_signed,
    input logic             b_signed,
    input logic             frac_mode,
    input logic             byte_mode,
    input logic             out_valid,
    input logic [RES_W-1:0] product
);
    localparam int SIGN_B = 32;
    localparam int BRES_W = 2 * BYTE_W;

    // R1: reset clears the outputs
    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && product == '0));

    // R2: valid follows with one cycle of latency
    a_r2_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r2_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R5: a doubled fractional result is always even
    a_r5_frac_even: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && frac_mode && !byte_mode) |=> !product[0]);

    // R6: an unsigned byte product never reaches past its 16 bits
    a_r6_byte_range: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && byte_mode && !a_signed && !b_signed) |=> product[RES_W-1:BRES_W] == '0);

    // R8: no operation means the result holds
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(product));

    // R9: the upper bits copy the result's sign bit
    a_r9_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (product[RES_W-1:SIGN_B] == '0 || product[RES_W-1:SIGN_B] == '1));
endmodule

bind mulsc_top mulsc_checker #(.BYTE_W(BYTE_W), .RES_W(RES_W)) u_mulsc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .a_signed  (a_signed),
    .b_signed  (b_signed),
    .frac_mode (frac_mode),
    .byte_mode (byte_mode),
    .out_valid (out_valid),
    .product   (product)
);

// File: tb/sim_mulsc_top.sv
// Bench: a behavioural reference built on wide integers, compared every clock.
module sim_mulsc_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [15:0] opa, opb;
    logic        a_signed, b_signed, frac_mode, byte_mode;
    logic        out_valid;
    logic [39:0] product;

    int          n_checks = 0;
    int          n_fails  = 0;
    logic        exp_valid;
    logic [39:0] exp_prod;

    always #(CLK_PERIOD/2) clk = ~clk;

    mulsc_top u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opa(opa), .opb(opb),
        .a_signed(a_signed), .b_signed(b_signed), .frac_mode(frac_mode),
        .byte_mode(byte_mode), .out_valid(out_valid), .product(product)
    );

    // Reference result computed from the requirements
    function automatic logic [39:0] model(input logic [15:0] a, input logic [15:0] b,
                                          input bit as, input bit bs, input bit fr, input bit by);
        longint va, vb, p;
        logic [63:0] pu;
        logic [32:0] t;
        if (by) begin
            va = as ? longint'($signed(a[7:0])) : longint'(a[7:0]);
            vb = bs ? longint'($signed(b[7:0])) : longint'(b[7:0]);
        end else begin
            va = as ? longint'($signed(a)) : longint'(a);
            vb = bs ? longint'($signed(b)) : longint'(b);
        end
        p = va * vb;
        if (!by && fr) begin
            pu = p * 2;
            t  = pu[32:0];
            return {{7{t[32]}}, t};
        end
        pu = p;
        return pu[39:0];
    endfunction

    function automatic string tag_of(input bit as, input bit bs, input bit fr, input bit by);
        if (by) return fr ? "R7" : "R6";
        if (fr) return "R5";
        if (as != bs) return "R4";
        return "R3";
    endfunction

    task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // One clock: drive at the falling edge, update the model at the rising edge, compare at the next falling edge
    task automatic step(input logic [15:0] a, input logic [15:0] b, input bit as, input bit bs,
                        input bit fr, input bit by, input bit v);
        string tag;
        opa = a; opb = b; a_signed = as; b_signed = bs;
        frac_mode = fr; byte_mode = by; in_valid = v;
        tag = v ? tag_of(as, bs, fr, by) : "R8";
        @(posedge clk);
        exp_valid = v;
        if (v) exp_prod = model(a, b, as, bs, fr, by);
        @(negedge clk);
        check("R2", {39'd0, out_valid}, {39'd0, exp_valid});
        check(tag, product, exp_prod);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        exp_valid = 1'b0;
        exp_prod  = '0;
        check("R1", {39'd0, out_valid}, 40'd0);
        check("R1", product, 40'd0);
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        logic [15:0] ext_v [4];
        ext_v[0] = 16'h0000; ext_v[1] = 16'h7FFF; ext_v[2] = 16'h8000; ext_v[3] = 16'hFFFF;
        in_valid = 0; opa = 0; opb = 0; a_signed = 0; b_signed = 0;
        frac_mode = 0; byte_mode = 0; exp_valid = 0; exp_prod = 0;
        @(negedge clk);
        do_reset();

        // R3/R4 directed: how each operand is extended
        step(16'h7FFF, 16'h8000, 1, 1, 0, 0, 1);
        check("R3", product, 40'hFFC0008000);
        step(16'hFFFF, 16'hFFFF, 0, 0, 0, 0, 1);
        check("R3", product, 40'h00FFFE0001);
        step(16'hFFFF, 16'hFFFF, 1, 0, 0, 0, 1);
        check("R4", product, 40'hFFFFFF0001);
        // R5: fractional -1.0 x -1.0 is not clamped, and 0.5 x 0.5
        step(16'h8000, 16'h8000, 1, 1, 1, 0, 1);
        check("R5", product, 40'h0080000000);
        step(16'h4000, 16'h4000, 1, 1, 1, 0, 1);
        check("R5", product, 40'h0020000000);
        // R6: the upper bytes are ignored
        step(16'h1280, 16'hAB80, 1, 1, 0, 1, 1);
        check("R6", product, 40'h0000004000);
        step(16'h12FF, 16'h34FF, 0, 0, 0, 1, 1);
        check("R6", product, 40'h000000FE01);
        // R7: frac_mode has no effect in byte mode
        step(16'h12FF, 16'h34FF, 0, 0, 1, 1, 1);
        check("R7", product, 40'h000000FE01);
        // R8: new operands without valid leave the result alone
        step(16'h7FFF, 16'h7FFF, 1, 1, 0, 0, 0);
        check("R8", product, 40'h000000FE01);

        // Extreme values under every flag combination
        for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++)
                for (int f = 0; f < 16; f++)
                    step(ext_v[i], ext_v[j], f[0], f[1], f[2], f[3], 1);

        // Random operands and modes, with idle cycles mixed in
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] r;
            r = $urandom;
            step(16'($urandom), 16'($urandom), r[0], r[1], r[2], r[3] & r[4], r[5] | r[6]);
        end

        // R1: reset in the middle of a run
        step(16'h1234, 16'h5678, 0, 0, 0, 0, 1);
        do_reset();
        step(16'h0003, 16'hFFFD, 0, 1, 0, 0, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule